// File: doc/BRIEF.md
# Register-Pointer Serial Slave with Bus Watchdog

This block is the register-access side of a two-wire serial slave for a memory-module temperature sensor. It answers one seven-bit bus address and holds a pointer that selects one 16-bit register. Words travel high byte first in both directions. A write carries the pointer byte and then, optionally, a data word. A read returns the word at the pointer as it stands. The pointer keeps its value between transactions, so a host can set it once and then poll the same register.

The identification words, the capability word and a small control register live inside the block. The trip-point and temperature registers belong to neighbouring logic. They are reached through a plain port set: the pointer value, a one-cycle write strobe with its data word, and a read-data input.

A watchdog counts system clocks while the clock line is low during a transfer. At a parameterised limit it drops the transfer and releases the data line. A bit in the control register turns the watchdog off.

Top module: `smb_ptr_slave`

## Requirements
- R1: The block acknowledges a transfer only when the first byte after a start carries the seven address bits {ADDR_PREFIX (default 0011), strap_i[2:0]} in bits 7..1. For any other address it leaves the data line released until the next start.
- R2: After reset the pointer, seen on reg_addr, is 00h. A read without a prior pointer write returns CAP_VALUE.
- R3: A read uses the pointer last written. Read transactions never change the pointer.
- R4: Read words leave high byte first, MSB first. The low byte follows a master ACK. A master NACK ends the transfer and the data line is released. While the clock is high the slave never changes its drive.
- R5: A write of pointer 01h..04h followed by two data bytes gives exactly one reg_wr pulse, with reg_addr equal to the pointer and reg_wdata equal to {first byte, second byte}.
- R6: A write that carries only a pointer byte updates the pointer and gives no reg_wr pulse.
- R7: Data writes to pointers 00h, 05h, 06h, 07h and any unimplemented pointer give no reg_wr pulse and leave the read-back value unchanged.
- R8: Pointer 06h reads 1131h. Pointer 07h reads A100h: device code A1h in the high byte and revision 00h in the low byte.
- R9: Any pointer other than 00h..07h and 22h reads 0000h.
- R10: If the clock line stays low for TMO_CYCLES system clocks while a transfer is active, the block returns to idle and releases the data line.
- R11: Pointer 22h bit 0 disables the watchdog when set. It resets to 0, is writable, and reads back as {15'b0, bit}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line (bus level) |
| strap_i | input | 3 | Board strap bits for the low address bits |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| reg_addr | output | 8 | Current pointer value |
| reg_wr | output | 1 | One-cycle write strobe for external registers |
| reg_wdata | output | 16 | Word written with reg_wr |
| reg_rdata | input | 16 | Read data for pointers 01h..05h |

## Verification
The watchdog and the slave's own bus drive can act in the same cycle. The bench provokes this by stopping the clock low right after the eighth address bit, while the slave is pulling the data line low for its acknowledge. With the watchdog enabled, the bench expects the pull-down to vanish after the limit and the next transaction to work. With the control bit set, the bench expects the pull-down to persist through the same wait and the acknowledge to complete normally.

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave #(
  parameter logic [3:0]  ADDR_PREFIX = 4'b0011,
  parameter logic [15:0] CAP_VALUE   = 16'h001F,
  parameter logic [15:0] MFG_ID      = 16'h1131,
  parameter logic [15:0] DEV_ID      = 16'hA100,
  parameter logic [7:0]  CTRL_PTR    = 8'h22,
  parameter int          TMO_CYCLES  = 3_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  strap_i,
  output logic        sda_oe,
  output logic [7:0]  reg_addr,
  output logic        reg_wr,
  output logic [15:0] reg_wdata,
  input  logic [15:0] reg_rdata
);
  localparam int TW = $clog2(TMO_CYCLES + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_t;

  st_t         st;
  logic        scl_q, sda_q, rd_mode, lsb_next, mack, tmo_dis, wr_q;
  logic [3:0]  bitcnt;
  logic [2:0]  byte_n;
  logic [7:0]  shreg, msb_q, ptr;
  logic [15:0] wdata_q, rd_word;
  logic [TW-1:0] tmo_cnt;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire ptr_rw   = (ptr >= 8'h01) && (ptr <= 8'h04);
  wire tmo_hit  = !tmo_dis && (st != ST_IDLE) && (tmo_cnt == TW'(TMO_CYCLES - 1));

  always_comb begin
    if (ptr == 8'h00)                        rd_word = CAP_VALUE;
    else if (ptr >= 8'h01 && ptr <= 8'h05)   rd_word = reg_rdata;
    else if (ptr == 8'h06)                   rd_word = MFG_ID;
    else if (ptr == 8'h07)                   rd_word = DEV_ID;
    else if (ptr == CTRL_PTR)                rd_word = {15'b0, tmo_dis};
    else                                     rd_word = 16'h0000;
  end

  assign sda_oe    = (st == ST_ACK) || (st == ST_TX && !shreg[7]);
  assign reg_addr  = ptr;
  assign reg_wr    = wr_q;
  assign reg_wdata = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; rd_mode <= 1'b0;
      lsb_next <= 1'b0; mack <= 1'b0; tmo_dis <= 1'b0; wr_q <= 1'b0;
      bitcnt <= '0; byte_n <= '0; shreg <= '0; msb_q <= '0; ptr <= '0;
      wdata_q <= '0; tmo_cnt <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      wr_q  <= 1'b0;
      tmo_cnt <= (scl_i || st == ST_IDLE || tmo_dis) ? '0 : tmo_cnt + 1'b1;
      if (tmo_hit || stop_c) begin
        st <= ST_IDLE;
      end else if (start_c) begin
        st <= ST_RX; bitcnt <= '0; byte_n <= '0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              byte_n <= byte_n + 3'd1;
              st     <= ST_ACK;
              case (byte_n)
                3'd0: if (shreg[7:1] != {ADDR_PREFIX, strap_i}) st <= ST_IDLE;
                      else rd_mode <= shreg[0];
                3'd1: ptr   <= shreg;
                3'd2: msb_q <= shreg;
                3'd3: begin
                  if (ptr_rw) begin wr_q <= 1'b1; wdata_q <= {msb_q, shreg}; end
                  if (ptr == CTRL_PTR) tmo_dis <= shreg[0];
                end
                default: st <= ST_IDLE;
              endcase
            end
          end
          ST_ACK: if (scl_fall) begin
            if (rd_mode) begin
              st <= ST_TX; shreg <= rd_word[15:8]; lsb_next <= 1'b1;
            end else st <= ST_RX;
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == 4'd7) begin st <= ST_MACK; bitcnt <= '0; end
            else begin shreg <= {shreg[6:0], 1'b0}; bitcnt <= bitcnt + 4'd1; end
          end
          ST_MACK: begin
            if (scl_rise) mack <= !sda_i;
            else if (scl_fall) begin
              if (mack) begin
                st <= ST_TX;
                shreg <= lsb_next ? rd_word[7:0] : rd_word[15:8];
                lsb_next <= !lsb_next;
              end else st <= ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  a_r10_tmo_release: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> !sda_oe);
  a_r5_wr_target: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_addr >= 8'h01 && reg_addr <= 8'h04));
  a_r3_ptr_hold_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX || st == ST_MACK) |=> $stable(ptr));
  a_r4_drive_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX && scl_i && scl_q) |=> $stable(sda_oe));
endmodule

// File: tb/smb_ptr_slave_test.sv
module smb_ptr_slave_test;
  localparam int TMO = 200;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] AW = {4'b0011, STRAP, 1'b0};
  localparam logic [7:0] AR = {4'b0011, STRAP, 1'b1};
  localparam logic [15:0] CAP = 16'h001F;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_oe, reg_wr;
  logic [7:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [15:0] extmem [0:7];
  logic [15:0] mdl [0:7];
  logic mdl_dis = 0;
  int vectors = 0, fails = 0, wr_cnt = 0;
  logic [7:0] last_a;
  logic [15:0] last_d;
  wire sda_bus = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  smb_ptr_slave #(.TMO_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(STRAP),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  assign reg_rdata = (reg_addr < 8'd8) ? extmem[reg_addr[2:0]] : 16'h0;

  always @(posedge clk) if (rst_n && reg_wr) begin
    wr_cnt <= wr_cnt + 1; last_a <= reg_addr; last_d <= reg_wdata;
    if (reg_addr < 8'd8) extmem[reg_addr[2:0]] <= reg_wdata;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [7:0] p);
    if (p == 8'h00) return CAP;
    if (p >= 8'h01 && p <= 8'h05) return mdl[p[2:0]];
    if (p == 8'h06) return 16'h1131;
    if (p == 8'h07) return 16'hA100;
    if (p == 8'h22) return {15'b0, mdl_dis};
    return 16'h0000;
  endfunction

  task automatic hold(input int n); repeat (n) @(negedge clk); endtask
  task automatic start_c();
    sda_m = 1; hold(1); scl_m = 1; hold(1); sda_m = 0; hold(1); scl_m = 0; hold(1);
  endtask
  task automatic stop_c();
    sda_m = 0; hold(1); scl_m = 1; hold(1); sda_m = 1; hold(2);
  endtask
  task automatic wbit(input logic b);
    sda_m = b; hold(1); scl_m = 1; hold(1);
    if (sda_bus !== b) begin fails++; $display("FAIL R4 actual=%b expected=%b (bus contention)", sda_bus, b); end
    hold(1); scl_m = 0; hold(1);
  endtask
  task automatic rbit(output logic b);
    sda_m = 1; hold(1); scl_m = 1; hold(1); b = sda_bus; hold(1); scl_m = 0; hold(1);
  endtask
  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(a); ack = !a;
  endtask
  task automatic rbyte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(!mack);
  endtask

  task automatic wr_reg(input logic [7:0] p, input logic with_data, input logic [15:0] d);
    logic ack;
    start_c(); wbyte(AW, ack); chk("R1 addr ack", {15'b0, ack}, 16'd1);
    wbyte(p, ack);
    if (with_data) begin wbyte(d[15:8], ack); wbyte(d[7:0], ack); end
    stop_c();
  endtask

  task automatic rd_reg(input logic setp, input logic [7:0] p, output logic [15:0] w);
    logic ack;
    if (setp) begin start_c(); wbyte(AW, ack); wbyte(p, ack); end
    start_c(); wbyte(AR, ack); chk("R1 read ack", {15'b0, ack}, 16'd1);
    rbyte(w[15:8], 1'b1); rbyte(w[7:0], 1'b0); stop_c();
    chk("R4 released after NACK", {15'b0, sda_oe}, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic ack;
    int n0;
    for (int i = 0; i < 8; i++) begin extmem[i] = 16'h0; mdl[i] = 16'h0; end
    extmem[5] = 16'h019C; mdl[5] = 16'h019C;
    hold(3); rst_n = 1; hold(2);
    chk("R2 reset pointer", {8'h0, reg_addr}, 16'h0000);
    chk("R2 reset oe", {15'b0, sda_oe}, 16'd0);

    rd_reg(0, 8'h00, w); chk("R2 capability", w, CAP);
    rd_reg(1, 8'h06, w); chk("R8 mfg id", w, exp_rd(8'h06));
    rd_reg(1, 8'h07, w); chk("R8 dev id", w, exp_rd(8'h07));
    rd_reg(0, 8'h07, w); chk("R3 sticky pointer", w, 16'hA100);

    n0 = wr_cnt; wr_reg(8'h01, 1, 16'h1234); mdl[1] = 16'h1234;
    chk("R5 one strobe", 16'(wr_cnt - n0), 16'd1);
    chk("R5 strobe addr", {8'h0, last_a}, 16'h0001);
    chk("R5 strobe data", last_d, 16'h1234);
    rd_reg(1, 8'h01, w); chk("R5 readback", w, exp_rd(8'h01));
    n0 = wr_cnt; wr_reg(8'h04, 1, 16'hBEEF); mdl[4] = 16'hBEEF;
    chk("R5 strobe data 04", last_d, 16'hBEEF);
    chk("R5 one strobe 04", 16'(wr_cnt - n0), 16'd1);

    n0 = wr_cnt; wr_reg(8'h05, 0, 16'h0);
    chk("R6 pointer only no strobe", 16'(wr_cnt - n0), 16'd0);
    chk("R6 pointer moved", {8'h0, reg_addr}, 16'h0005);
    rd_reg(0, 8'h05, w); chk("R6 read via new pointer", w, 16'h019C);

    n0 = wr_cnt;
    wr_reg(8'h06, 1, 16'hFFFF); wr_reg(8'h05, 1, 16'h7777);
    wr_reg(8'h00, 1, 16'h5555); wr_reg(8'h30, 1, 16'h4444);
    chk("R7 no strobe for read-only", 16'(wr_cnt - n0), 16'd0);
    rd_reg(1, 8'h06, w); chk("R7 mfg unchanged", w, 16'h1131);
    rd_reg(1, 8'h05, w); chk("R7 temp unchanged", w, 16'h019C);
    rd_reg(1, 8'h00, w); chk("R7 cap unchanged", w, CAP);

    rd_reg(1, 8'h10, w); chk("R9 unimplemented 10h", w, 16'h0000);
    rd_reg(1, 8'h23, w); chk("R9 unimplemented 23h", w, 16'h0000);

    start_c(); wbyte({4'b0011, 3'b100, 1'b1}, ack); chk("R1 wrong strap nack", {15'b0, ack}, 16'd0);
    wbit(1'b1); wbit(1'b0); stop_c();
    start_c(); wbyte({4'b1010, STRAP, 1'b1}, ack); chk("R1 wrong prefix nack", {15'b0, ack}, 16'd0);
    stop_c();

    rd_reg(1, 8'h22, w); chk("R11 control reset", w, 16'h0000);

    start_c();
    for (int i = 7; i >= 0; i--) wbit(AW[i]);
    hold(2); chk("R10 ack driven before wait", {15'b0, sda_oe}, 16'd1);
    hold(TMO + 10);
    chk("R10 timeout released", {15'b0, sda_oe}, 16'd0);
    stop_c();
    rd_reg(1, 8'h01, w); chk("R10 recovers after abort", w, 16'h1234);

    wr_reg(8'h22, 1, 16'h0001); mdl_dis = 1;
    rd_reg(1, 8'h22, w); chk("R11 control readback", w, 16'h0001);
    start_c();
    for (int i = 7; i >= 0; i--) wbit(AW[i]);
    hold(TMO + 10);
    chk("R11 watchdog off keeps ack", {15'b0, sda_oe}, 16'd1);
    rbit(ack); chk("R11 ack completes", {15'b0, ack}, 16'd0);
    stop_c();
    wr_reg(8'h22, 1, 16'h0000); mdl_dis = 0;
    rd_reg(1, 8'h22, w); chk("R11 control cleared", w, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule